// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Decode Interlock

This block performs 32-bit integer multiplication and division beside the main pipeline. Decode launches an operation with a two-bit opcode and two operands. The unit then iterates on its own while independent instructions keep flowing. When the operation finishes, the full result lands in two result registers, HI and LO. Decode is held back only when an instruction needs something the unit cannot give yet. That happens when it asks to read HI or LO, or when it tries to launch another operation, while the unit is still busy.

Multiplication retires four multiplier bits per cycle and takes 8 cycles. Division uses the restoring method, produces one quotient bit per cycle and takes 32 cycles. Both work on unsigned or two's-complement operands. The datapaths work on magnitudes and apply the sign at the end. Division by zero does not trap: it finishes in the normal time with a fixed, defined result.

The controller is a three-state machine:
- **ST_IDLE** moves to **ST_MUL** when a multiply is launched, and to **ST_DIV** when a divide is launched.
- **ST_MUL** and **ST_DIV** each count down their fixed step budget. Each returns to **ST_IDLE** on its last step; the named transitions are "mul done" and "div done".
- On the cycle of that return, HI and LO are written.

Top module: `mdu_interlock`

## Requirements
- R1: A launch (issue_valid high while busy is low) is accepted at the clock edge, and busy is high in the next cycle.
- R2: Opcode encoding: issue_op[1]=0 selects multiply, issue_op[1]=1 selects divide, and issue_op[0]=1 selects signed. A multiply keeps busy high for exactly 8 cycles and leaves the 64-bit product with its upper half in HI and its lower half in LO.
- R3: A divide keeps busy high for exactly 32 cycles. LO receives the quotient truncated toward zero, and HI the remainder, which takes the dividend's sign in signed mode.
- R4: A divide by zero takes the normal 32 cycles and leaves LO all ones and HI equal to the dividend, in both signed and unsigned mode.
- R5: The signed divide of 0x80000000 by 0xFFFFFFFF leaves LO = 0x80000000 and HI = 0.
- R6: stall is high exactly when busy is high and either rd_req or issue_valid is high. While idle, stall is low whatever the inputs are.
- R7: An issue_valid presented while busy is ignored. The running operation keeps its length and its result.
- R8: rd_data shows HI when rd_sel=1 and LO when rd_sel=0. HI and LO change only at the edge where busy falls, so a stalled read sees the new values in the cycle after the stall drops.
- R9: After reset the unit is idle, HI and LO read as zero, and stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Decode presents a multiply or divide |
| issue_op | input | 2 | Bit 1: divide; bit 0: signed |
| issue_a | input | 32 | Multiplicand or dividend |
| issue_b | input | 32 | Multiplier or divisor |
| rd_req | input | 1 | Decode holds an instruction that reads HI or LO |
| rd_sel | input | 1 | 1 reads HI, 0 reads LO |
| stall | output | 1 | Hold decode this cycle |
| busy | output | 1 | An operation is in progress |
| rd_data | output | 32 | Selected result register |

## Verification
The result timing is fixed by the operation:
- busy is due one edge after the launch edge.
- A product is due 8 edges after launch, and a quotient and remainder 32 edges after launch. In both cases it appears in HI/LO on the same edge that busy falls.
- stall and rd_data follow the inputs within the same cycle.

The bench drives inputs on the falling edge and samples shortly after it. It counts the busy cycles of each operation and compares the count with 8 or 32. It reads HI and LO only once busy has dropped. In the middle of a run it raises rd_req and a conflicting issue_valid, and checks that stall rises while the final result and the length of the run are unchanged.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV
    } mdu_state_e;

    localparam int OP_DIV_BIT    = 1;
    localparam int OP_SIGNED_BIT = 0;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int W        = 32,
    parameter int MUL_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_div,
    output logic busy,
    output logic mul_run,
    output logic div_run,
    output logic mul_last,
    output logic div_last
);
    localparam int MUL_CYC = W / MUL_BITS;
    localparam int DIV_CYC = W;
    localparam int CW      = $clog2(DIV_CYC);

    mdu_state_e      state, state_n;
    logic [CW-1:0]   cnt, cnt_n;

    // next state and step budget
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = start_div ? ST_DIV : ST_MUL;
                    cnt_n   = start_div ? CW'(DIV_CYC - 1) : CW'(MUL_CYC - 1);
                end
            end
            ST_MUL, ST_DIV: begin
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n   = cnt - 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        mul_run  = 1'b0;
        div_run  = 1'b0;
        mul_last = 1'b0;
        div_last = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_MUL: begin
                busy     = 1'b1;
                mul_run  = 1'b1;
                mul_last = (cnt == '0);
            end
            ST_DIV: begin
                busy     = 1'b1;
                div_run  = 1'b1;
                div_last = (cnt == '0);
            end
            default: ;
        endcase
    end

    // R7: a running operation keeps its state until its budget is spent
    a_r7_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cnt != '0) |=> (state == $past(state)));

    // R2: a multiply launch loads the multiply budget
    a_r2_mul_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !start_div) |=>
            (state == ST_MUL && cnt == CW'(MUL_CYC - 1)));

    // R3: a divide launch loads the divide budget
    a_r3_div_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && start_div) |=>
            (state == ST_DIV && cnt == CW'(DIV_CYC - 1)));
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
    parameter int W    = 32,
    parameter int BITS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           is_signed,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] result
);
    logic [2*W-1:0] acc, mc, sum_n;
    logic [W-1:0]   mp, mag_a, mag_b;
    logic           neg;

    always_comb begin
        mag_a  = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
        mag_b  = (is_signed && b[W-1]) ? (~b + 1'b1) : b;
        sum_n  = acc + mc * {{(2*W-BITS){1'b0}}, mp[BITS-1:0]};
        result = neg ? (~sum_n + 1'b1) : sum_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            mc  <= '0;
            mp  <= '0;
            neg <= 1'b0;
        end else if (load) begin
            acc <= '0;
            mc  <= {{W{1'b0}}, mag_a};
            mp  <= mag_b;
            neg <= is_signed & (a[W-1] ^ b[W-1]);
        end else if (step) begin
            acc <= sum_n;
            mc  <= mc << BITS;
            mp  <= mp >> BITS;
        end
    end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         is_signed,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    logic [W-1:0] r_q, q_q, dvs, dvd_orig, mag_a, mag_b, rem_n, quo_n;
    logic [W:0]   shifted, diff;
    logic         take, neg_q, neg_r, by_zero;

    always_comb begin
        mag_a   = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
        mag_b   = (is_signed && b[W-1]) ? (~b + 1'b1) : b;
        shifted = {r_q, q_q[W-1]};
        diff    = shifted - {1'b0, dvs};
        take    = ~diff[W];
        rem_n   = take ? diff[W-1:0] : shifted[W-1:0];
        quo_n   = {q_q[W-2:0], take};
        quot    = by_zero ? {W{1'b1}} : (neg_q ? (~quo_n + 1'b1) : quo_n);
        rem     = by_zero ? dvd_orig  : (neg_r ? (~rem_n + 1'b1) : rem_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            q_q      <= '0;
            dvs      <= '0;
            dvd_orig <= '0;
            neg_q    <= 1'b0;
            neg_r    <= 1'b0;
            by_zero  <= 1'b0;
        end else if (load) begin
            r_q      <= '0;
            q_q      <= mag_a;
            dvs      <= mag_b;
            dvd_orig <= a;
            neg_q    <= is_signed & (a[W-1] ^ b[W-1]);
            neg_r    <= is_signed & a[W-1];
            by_zero  <= (b == '0);
        end else if (step) begin
            r_q <= rem_n;
            q_q <= quo_n;
        end
    end
endmodule

// File: rtl/mdu_interlock.sv
module mdu_interlock
    import mdu_pkg::*;
#(
    parameter int W        = 32,
    parameter int MUL_BITS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_valid,
    input  logic [1:0]   issue_op,
    input  logic [W-1:0] issue_a,
    input  logic [W-1:0] issue_b,
    input  logic         rd_req,
    input  logic         rd_sel,
    output logic         stall,
    output logic         busy,
    output logic [W-1:0] rd_data
);
    logic           launch, mul_run, div_run, mul_last, div_last;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quot, rem, hi_q, lo_q;

    assign launch  = issue_valid && !busy;
    assign stall   = busy && (rd_req || issue_valid);
    assign rd_data = rd_sel ? hi_q : lo_q;

    mdu_ctrl #(.W(W), .MUL_BITS(MUL_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .start_div(issue_op[OP_DIV_BIT]),
        .busy     (busy),
        .mul_run  (mul_run),
        .div_run  (div_run),
        .mul_last (mul_last),
        .div_last (div_last)
    );

    mdu_mul #(.W(W), .BITS(MUL_BITS)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch && !issue_op[OP_DIV_BIT]),
        .step     (mul_run),
        .is_signed(issue_op[OP_SIGNED_BIT]),
        .a        (issue_a),
        .b        (issue_b),
        .result   (prod)
    );

    mdu_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch && issue_op[OP_DIV_BIT]),
        .step     (div_run),
        .is_signed(issue_op[OP_SIGNED_BIT]),
        .a        (issue_a),
        .b        (issue_b),
        .quot     (quot),
        .rem      (rem)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (mul_last) begin
            hi_q <= prod[2*W-1:W];
            lo_q <= prod[W-1:0];
        end else if (div_last) begin
            hi_q <= rem;
            lo_q <= quot;
        end
    end

    // R1: an accepted launch makes the unit busy on the next cycle
    a_r1_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !busy) |=> busy);

    // R8: result registers move only on the edge where busy falls
    a_r8_hilo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hi_q) || !$stable(lo_q)) |-> $fell(busy));

    // R6: no stall in the cycle after completion
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !stall);
endmodule

// File: tb/tb_mdu_interlock.sv
module tb_mdu_interlock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_op = 2'b00;
    logic [31:0] issue_a = '0, issue_b = '0;
    logic        rd_req = 1'b0, rd_sel = 1'b0;
    logic        stall, busy;
    logic [31:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mdu_interlock dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_a(issue_a), .issue_b(issue_b), .rd_req(rd_req), .rd_sel(rd_sel),
        .stall(stall), .busy(busy), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected {HI, LO}
    function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa, sb, q, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (!op[1]) begin
            if (op[0]) return 64'(sa * sb);
            return {32'd0, a} * {32'd0, b};
        end
        if (b == 32'd0) return {a, 32'hFFFF_FFFF};
        if (op[0]) begin
            q = sa / sb;
            r = sa % sb;
            return {r[31:0], q[31:0]};
        end
        return {a % b, a / b};
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input bit interfere);
        logic [63:0] exp;
        string       tag;
        int          n;
        exp = model(op, a, b);
        if (!op[1]) tag = "R2";
        else if (b == 0) tag = "R4";
        else if (op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) tag = "R5";
        else tag = "R3";
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_a = a; issue_b = b; rd_req = 1'b1;
        #1 check("R6 idle no stall", 64'(stall), 64'd0);
        @(negedge clk);
        issue_valid = 1'b0; rd_req = 1'b0;
        #1 check("R1 busy after launch", 64'(busy), 64'd1);
        n = 0;
        while (busy && n < 100) begin
            n++;
            rd_req      = (n == 2);
            issue_valid = interfere && (n >= 3) && (n <= 5);
            if (issue_valid) begin
                issue_op = ~op; issue_a = $urandom; issue_b = $urandom;
            end
            #1;
            if (rd_req)      check("R6 stall on read", 64'(stall), 64'd1);
            if (issue_valid) check("R7 stall on issue", 64'(stall), 64'd1);
            @(negedge clk);
            issue_valid = 1'b0; rd_req = 1'b0;
            #1;
        end
        check({tag, " busy length"}, 64'(n), op[1] ? 64'd32 : 64'd8);
        rd_req = 1'b1; rd_sel = 1'b0;
        #1 check("R6 no stall after done", 64'(stall), 64'd0);
        check({tag, " R8 LO"}, 64'(rd_data), 64'(exp[31:0]));
        rd_sel = 1'b1;
        #1 check({tag, " R8 HI"}, 64'(rd_data), 64'(exp[63:32]));
        if (interfere) check("R7 result kept", 64'(rd_data), 64'(exp[63:32]));
        rd_req = 1'b0; rd_sel = 1'b0;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 6)
            0: return 32'd0;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return $urandom % 16;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        int unsigned seed;
        seed = 32'd20240517;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        rd_req = 1'b1;
        #1 check("R9 reset busy", 64'(busy), 64'd0);
        check("R9 reset stall", 64'(stall), 64'd0);
        check("R9 reset LO", 64'(rd_data), 64'd0);
        rd_sel = 1'b1;
        #1 check("R9 reset HI", 64'(rd_data), 64'd0);
        rd_req = 1'b0; rd_sel = 1'b0;

        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R2 unsigned max
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R2 signed -1*-1
        run_op(2'b01, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1); // R2 with R7 interference
        run_op(2'b11, 32'hFFFF_FFF9, 32'd2, 1'b0);         // R3 -7/2
        run_op(2'b10, 32'd100, 32'd7, 1'b1);               // R3 with R7 interference
        run_op(2'b11, 32'hFFFF_FF00, 32'd0, 1'b0);         // R4 signed
        run_op(2'b10, 32'h1234_5678, 32'd0, 1'b0);         // R4 unsigned
        run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R5
        for (int i = 0; i < 40; i++)
            run_op(2'($urandom), pick(), pick(), 1'($urandom));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule